// File: doc/BRIEF.md
# SPI register access sequencer

This block runs one register read or one register write on an external transceiver over a four-wire SPI link. The user supplies a register address, a direction flag and a write byte, then pulses start. The block builds a three-byte frame and sends it with chip select held low for the whole frame. It returns the byte read back and a one-cycle done pulse.

The frame begins with a 16-bit instruction word. Its top bit gives the direction, the next three bits give the byte count, and the lowest twelve bits hold the register address. The data byte follows the instruction word. One byte engine, with a programmable clock divider, shifts every byte. The sequencer hands it the three bytes one after another through a request/acknowledge handshake. The link uses mode 1 timing: the clock idles low, and each bit is sampled on the falling edge.

Top module: `spi_reg_access`

## Requirements
- R1: Bit 15 of the instruction word (the first bit on MOSI) is 1 for a write (`wr_i`=1) and 0 for a read.
- R2: Instruction bits 14..12 are always sent as 000. Bits 11..0 carry `addr_i[11:0]`. Address bits 15..12 have no effect on the frame.
- R3: One frame is 24 bits, each byte MSB first, in this order: instruction bits 15..8, instruction bits 7..0, data byte. The data byte is `wdata_i` for a write and 0x00 for a read.
- R4: `sclk_o` is low whenever `cs_n_o` is high. MOSI does not change while `sclk_o` is high, so a slave may sample it on the falling edge.
- R5: Every high phase of `sclk_o` lasts exactly `div_i` system clocks. A `div_i` of 0 behaves as 1.
- R6: `cs_n_o` falls before the first `sclk_o` edge. It stays low for exactly 24 `sclk_o` pulses and then returns high.
- R7: After a read, `rdata_o` holds the 8 MISO bits sampled on the falling edges of the third byte, MSB first. A write frame leaves `rdata_o` unchanged.
- R8: `mosi_o` is low whenever `cs_n_o` is high, including after a write.
- R9: A start pulse is ignored while `busy_o` is high, including the cycle in which `done_o` is high.
- R10: `busy_o` is high from the cycle after an accepted start up to and including the `done_o` cycle. `done_o` is high for one cycle, one cycle after `cs_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | 16 | SCLK half-period in system clocks (0 treated as 1) |
| start_i | input | 1 | Start pulse for one access |
| wr_i | input | 1 | 1 = write, 0 = read; sampled with start |
| addr_i | input | 16 | Register address; sampled with start |
| wdata_i | input | 8 | Write data byte; sampled with start |
| rdata_o | output | 8 | Byte returned by the last read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
Two events can fall in one cycle: the done pulse that closes one access, and a start pulse asking for the next. The bench drives start in exactly the cycle where `done_o` is seen high, then watches chip select, busy and done for a long window afterwards. The start counts as correctly ignored only if chip select stays high, no clock pulses appear, busy stays low and no second done arrives. A second test raises start in the middle of a frame with inverted address, data and direction. The scoreboard then requires that the captured frame and the returned byte match only the original request.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 3;
    localparam int INSTR_W   = 16;
    localparam int DIV_W     = 16;
    localparam logic [INSTR_W-1:0] ADDR_KEEP = 16'h0FFF;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_TAIL,
        ENG_ACK
    } eng_state_e;

    typedef enum logic [2:0] {
        FRM_IDLE,
        FRM_LEAD,
        FRM_ISSUE,
        FRM_WAIT,
        FRM_RELEASE,
        FRM_FINISH
    } frm_state_e;

    // Direction on top, count field forced to zero, twelve address bits below.
    function automatic logic [INSTR_W-1:0] make_instr(input logic wr,
                                                      input logic [INSTR_W-1:0] addr);
        logic [INSTR_W-1:0] kept;
        kept = addr & ADDR_KEEP;
        return {wr, kept[INSTR_W-2:0]};
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_reg_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int CW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] div_i,
    input  logic          req_i,
    input  logic [DW-1:0] tx_i,
    output logic          ack_o,
    output logic [DW-1:0] rx_o,
    output logic          idle_o,
    output logic          sclk_o,
    output logic          mosi_o,
    input  logic          miso_i
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);

    typedef struct packed {
        eng_state_e    st;
        logic [CW-1:0] cnt;
        logic [EW-1:0] edges;
        logic          sclk;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } eng_regs_t;

    eng_regs_t r_q, r_d;
    logic [CW-1:0] lim;
    logic          half_done;

    assign lim       = (div_i == '0) ? CW'(1) : div_i;
    assign half_done = (r_q.cnt >= lim - CW'(1));

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ENG_IDLE: begin
                r_d.sclk = 1'b0;
                if (req_i) begin
                    r_d.tx    = tx_i;
                    r_d.rx    = '0;
                    r_d.cnt   = '0;
                    r_d.edges = '0;
                    r_d.st    = ENG_RUN;
                end
            end
            ENG_RUN: begin
                if (half_done) begin
                    r_d.cnt  = '0;
                    r_d.sclk = ~r_q.sclk;
                    if (!r_q.sclk) begin
                        // leading (rising) edge: next bit goes out, first bit already there
                        if (r_q.edges != '0) r_d.tx = {r_q.tx[DW-2:0], 1'b0};
                    end else begin
                        // trailing (falling) edge: sample the device
                        r_d.rx = {r_q.rx[DW-2:0], miso_i};
                    end
                    r_d.edges = r_q.edges + EW'(1);
                    if (r_q.edges == EW'(EDGES - 1)) r_d.st = ENG_TAIL;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ENG_TAIL: begin
                if (half_done) begin
                    r_d.cnt = '0;
                    r_d.st  = ENG_ACK;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ENG_ACK: begin
                r_d.tx = '0;
                r_d.st = ENG_IDLE;
            end
            default: r_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ENG_IDLE, cnt: '0, edges: '0, sclk: 1'b0, tx: '0, rx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o  = (r_q.st == ENG_ACK);
    assign rx_o   = r_q.rx;
    assign idle_o = (r_q.st == ENG_IDLE);
    assign sclk_o = r_q.sclk;
    assign mosi_o = r_q.tx[DW-1];

    // R4: clock only leaves its low idle level while bits are being shifted
    p_sclk_low_outside_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ENG_RUN) |-> !r_q.sclk);

    // R4: the outgoing bit holds still across a high clock phase
    p_mosi_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sclk && r_d.sclk) |=> $stable(mosi_o));

    // R6: acknowledge is a single-cycle event
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_reg_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = NUM_BYTES,
    parameter int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic [IW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          eng_ack_i,
    input  logic [DW-1:0] eng_rx_i,
    output logic          eng_req_o,
    output logic [DW-1:0] eng_tx_o,
    output logic          cs_n_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    localparam int FW = DW * NB;
    localparam int XW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        frm_state_e    st;
        logic [FW-1:0] frame;
        logic          wr;
        logic [XW-1:0] idx;
        logic          cs_n;
        logic          busy;
        logic          done;
        logic [DW-1:0] rdata;
    } frm_regs_t;

    frm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            FRM_IDLE: begin
                if (start_i) begin
                    r_d.frame = {make_instr(wr_i, addr_i), (wr_i ? wdata_i : '0)};
                    r_d.wr    = wr_i;
                    r_d.idx   = '0;
                    r_d.cs_n  = 1'b0;
                    r_d.busy  = 1'b1;
                    r_d.st    = FRM_LEAD;
                end
            end
            FRM_LEAD:  r_d.st = FRM_ISSUE;
            FRM_ISSUE: r_d.st = FRM_WAIT;
            FRM_WAIT: begin
                if (eng_ack_i) begin
                    if (r_q.idx == XW'(NB - 1)) begin
                        if (!r_q.wr) r_d.rdata = eng_rx_i;
                        r_d.cs_n = 1'b1;
                        r_d.st   = FRM_RELEASE;
                    end else begin
                        r_d.idx   = r_q.idx + XW'(1);
                        r_d.frame = r_q.frame << DW;
                        r_d.st    = FRM_ISSUE;
                    end
                end
            end
            FRM_RELEASE: begin
                r_d.done = 1'b1;
                r_d.st   = FRM_FINISH;
            end
            FRM_FINISH: begin
                r_d.done = 1'b0;
                r_d.busy = 1'b0;
                r_d.st   = FRM_IDLE;
            end
            default: r_d.st = FRM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: FRM_IDLE, frame: '0, wr: 1'b0, idx: '0, cs_n: 1'b1,
                     busy: 1'b0, done: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign eng_req_o = (r_q.st == FRM_ISSUE);
    assign eng_tx_o  = r_q.frame[FW-1 -: DW];
    assign cs_n_o    = r_q.cs_n;
    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign rdata_o   = r_q.rdata;

    // R10: completion is reported only with chip select already released
    p_done_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o);

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: busy drops only right after the done pulse
    p_busy_ends_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R6: an engine acknowledge only arrives while one is awaited
    p_ack_only_when_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ack_i |-> (r_q.st == FRM_WAIT));

    // R9: a start seen while busy does not restart the frame
    p_start_ignored_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && r_q.st != FRM_FINISH) |=> busy_o);

endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
    import spi_reg_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = NUM_BYTES,
    parameter int IW = INSTR_W,
    parameter int CW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] div_i,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic [IW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          busy_o,
    output logic          cs_n_o,
    output logic          sclk_o,
    output logic          mosi_o,
    input  logic          miso_i
);
    logic          eng_req;
    logic          eng_ack;
    logic          eng_idle;
    logic [DW-1:0] eng_tx;
    logic [DW-1:0] eng_rx;

    spi_frame_ctrl #(.DW(DW), .NB(NB), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .eng_ack_i (eng_ack),
        .eng_rx_i  (eng_rx),
        .eng_req_o (eng_req),
        .eng_tx_o  (eng_tx),
        .cs_n_o    (cs_n_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rdata_o   (rdata_o)
    );

    spi_byte_engine #(.DW(DW), .CW(CW)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .req_i  (eng_req),
        .tx_i   (eng_tx),
        .ack_o  (eng_ack),
        .rx_o   (eng_rx),
        .idle_o (eng_idle),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .miso_i (miso_i)
    );

    // R6: the engine never shifts a byte outside an asserted chip select
    p_engine_inside_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_idle |-> !cs_n_o);

    // R8: the data line rests low whenever the device is deselected
    p_mosi_low_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !mosi_o);

    // R4: clock idles low while deselected
    p_sclk_idle_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

endmodule

// File: tb/tb_spi_reg_access.sv
module tb_spi_reg_access;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_i = 16'd3;
    logic        start_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        done_o, busy_o, cs_n_o, sclk_o, mosi_o;
    logic        miso_i = 1'b1;

    always #2.5 clk = ~clk;

    spi_reg_access dut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .start_i(start_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o),
        .busy_o(busy_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .miso_i(miso_i)
    );

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    logic [23:0] exp_frame_q[$];
    logic [7:0]  exp_rd_q[$];
    logic [7:0]  slv_rd = '0;
    logic [7:0]  last_rd = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor and device model, working on the falling system clock.
    logic        prev_cs_n = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
    logic        mosi_rise = 1'b0;
    logic [23:0] cap = '0;
    int          bits = 0;
    int          hcnt = 0;
    int          lim;

    always @(negedge clk) begin
        if (rst_n) begin
            lim = (div_i == 0) ? 1 : int'(div_i);
            if (prev_cs_n && !cs_n_o) begin
                bits = 0;
                cap  = '0;
                chk(!sclk_o, "R6 clock low when select falls", 32'(sclk_o), 0);
            end
            if (cs_n_o) begin
                chk(!sclk_o, "R4 clock idle while deselected", 32'(sclk_o), 0);
                chk(!mosi_o, "R8 data low while deselected", 32'(mosi_o), 0);
            end
            if (sclk_o && !prev_sclk) begin
                hcnt      = 1;
                mosi_rise = mosi_o;
                miso_i    = (bits >= 16) ? slv_rd[7-(bits-16)] : 1'b1;
            end else if (sclk_o) begin
                hcnt++;
            end
            if (!sclk_o && prev_sclk) begin
                chk(hcnt == lim, "R5 high phase width", 32'(hcnt), 32'(lim));
                chk(mosi_o == mosi_rise, "R4 data stable while clock high",
                    32'(mosi_o), 32'(mosi_rise));
                cap = {cap[22:0], mosi_o};
                bits++;
            end
            if (!prev_cs_n && cs_n_o) begin
                chk(bits == 24, "R6 pulses per frame", 32'(bits), 24);
                if (exp_frame_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected frame", 32'(cap), 0);
                end else begin
                    automatic logic [23:0] ef = exp_frame_q.pop_front();
                    chk(cap == ef, "R1/R2/R3 frame contents", 32'(cap), 32'(ef));
                end
            end
            if (done_o) begin
                chk(cs_n_o, "R10 done after select release", 32'(cs_n_o), 1);
                chk(!prev_done, "R10 done one cycle", 32'(prev_done), 0);
                chk(busy_o, "R10 busy during done", 32'(busy_o), 1);
                if (exp_rd_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'(rdata_o), 0);
                end else begin
                    automatic logic [7:0] er = exp_rd_q.pop_front();
                    chk(rdata_o == er, "R7 read byte", 32'(rdata_o), 32'(er));
                end
            end
            prev_cs_n = cs_n_o;
            prev_sclk = sclk_o;
            prev_done = done_o;
        end
    end

    // Driver: queue the expected frame and read byte, then run one access.
    // mode 0 plain, 1 = extra start mid-frame, 2 = extra start in the done cycle
    task automatic run_access(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                              input logic [7:0] sb, input logic [15:0] dv, input int mode);
        exp_frame_q.push_back({wr, 3'b000, addr[11:0], (wr ? wd : 8'h00)});
        if (!wr) last_rd = sb;
        exp_rd_q.push_back(last_rd);
        @(negedge clk);
        div_i   = dv;
        slv_rd  = sb;
        wr_i    = wr;
        addr_i  = addr;
        wdata_i = wd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R10 busy after start", 32'(busy_o), 1);
        addr_i  = ~addr;
        wdata_i = ~wd;
        wr_i    = ~wr;
        if (mode == 1) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        if (mode == 2) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R10 busy cleared after done", 32'(busy_o), 0);
        if (mode == 2) begin
            for (int i = 0; i < 60; i++) begin
                if (!cs_n_o || busy_o || done_o) begin
                    chk(1'b0, "R9 start in done cycle accepted",
                        32'({cs_n_o, busy_o, done_o}), 32'(3'b100));
                    break;
                end
                @(negedge clk);
            end
            chk(cs_n_o && !busy_o, "R9 stays idle after done-cycle start",
                32'({cs_n_o, busy_o}), 32'(2'b10));
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R10 actual=no_completion expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o, "R6 reset select high", 32'(cs_n_o), 1);
        chk(!sclk_o, "R4 reset clock low", 32'(sclk_o), 0);
        chk(!mosi_o, "R8 reset data low", 32'(mosi_o), 0);
        chk(!busy_o && !done_o, "R10 reset idle", 32'({busy_o, done_o}), 0);
        chk(rdata_o == 8'h00, "R7 reset read byte", 32'(rdata_o), 0);

        run_access(1'b1, 16'h0123, 8'hA5, 8'h00, 16'd3, 0);  // R1 write
        run_access(1'b0, 16'h0ABC, 8'hFF, 8'h3C, 16'd3, 0);  // R7 read
        run_access(1'b0, 16'hF45A, 8'h77, 8'hC3, 16'd1, 0);  // R2 upper bits dropped
        run_access(1'b1, 16'h8FFF, 8'h5A, 8'h11, 16'd0, 0);  // R5 zero divider
        run_access(1'b1, 16'h0055, 8'h81, 8'h22, 16'd5, 1);  // R9 mid-frame start
        run_access(1'b0, 16'h0211, 8'h00, 8'h7E, 16'd4, 2);  // R9 done-cycle start
        run_access(1'b1, 16'h0333, 8'h00, 8'h99, 16'd2, 0);  // R7 write keeps read byte

        chk(exp_frame_q.size() == 0, "R6 all frames seen", 32'(exp_frame_q.size()), 0);
        chk(exp_rd_q.size() == 0, "R10 all done pulses seen", 32'(exp_rd_q.size()), 0);
        chk(rdata_o == 8'h7E, "R7 read byte held after write", 32'(rdata_o), 32'h7E);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule